// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Threshold Unit

This unit sits beside the storage core of a FIFO. It keeps two threshold registers, an empty-side threshold and a full-side threshold, and compares them against the occupancy count that the core supplies to raise an almost-empty and an almost-full indication. The thresholds are `W` bits wide, where the FIFO depth is `2**W` words. The occupancy count arrives on a `W+1` bit bus so that a completely full FIFO can be represented.

A master reset loads both thresholds with a default. The level of the load strobe during that reset selects which default is used. The same reset latches whether later programming is done one bit at a time or one word at a time. While the load strobe is high, the write enable programs the thresholds and the read enable returns them, one register per access, on a registered readback bus. A partial reset restarts the programming sequence but keeps the programmed values.

Top module: `pfl_offset_loader`

## Requirements
- R1: While `mrst` is high, both thresholds load a default. The default is 127 when `cfg_ld` is low and 1023 when `cfg_ld` is high. If that value does not fit in `W` bits, the default saturates to all ones.
- R2: A cycle with `prst` high and `mrst` low leaves both thresholds unchanged. It also returns the serial bit position and both word slots (write and read) to the empty-side threshold.
- R3: In serial mode, each edge with `cfg_ld` and `wr_en` high stores `ser_bit` at the current stream position, then advances the position. Positions 0..W-1 are empty-threshold bits 0..W-1, and positions W..2W-1 are full-threshold bits 0..W-1.
- R4: A serial stream cut short changes only the bits already shifted, and all other bits keep their values. After position 2W-1 the position wraps to 0.
- R5: On each `mrst` cycle, `ser_sel` high selects serial mode and low selects word mode. `ser_sel` has no effect at any other time.
- R6: In word mode, each edge with `cfg_ld` and `wr_en` high writes `wr_data` to one threshold. The writes go in the order empty-side, full-side, then back to empty-side.
- R7: Each edge with `cfg_ld` and `rd_en` high places one threshold on `rd_data`, valid after that edge. The reads go in the order empty-side, full-side, then repeating. `rd_data` holds its value otherwise, and it is 0 after master reset.
- R8: `almost_empty` is high exactly when `fill_count` is less than or equal to the empty-side threshold.
- R9: `almost_full` is high exactly when `2**W - fill_count` is less than or equal to the full-side threshold.
- R10: With `cfg_ld` low, `wr_en`, `rd_en`, `wr_data` and `ser_bit` change neither threshold nor `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| cfg_ld | input | 1 | Threshold access strobe; its level at master reset selects the default |
| wr_en | input | 1 | Programming write enable (used while cfg_ld is high) |
| rd_en | input | 1 | Threshold readback enable (used while cfg_ld is high) |
| ser_sel | input | 1 | Programming method, sampled at master reset (1 = serial) |
| ser_bit | input | 1 | Serial programming bit |
| wr_data | input | W | Word-mode threshold value |
| fill_count | input | W+1 | Current FIFO occupancy, 0 to 2**W |
| rd_data | output | W | Registered threshold readback |
| almost_empty | output | 1 | Occupancy at or below the empty-side threshold |
| almost_full | output | 1 | Free space at or below the full-side threshold |

## Verification
A stuck or misdirected stream position or word slot does not show on the flags until the occupancy crosses the affected threshold. It does show on the next two-word readback, one cycle after each read edge. For that reason every programming scenario is followed at once by a readback and by an occupancy sweep around both thresholds, plus the extremes 0 and 2**W. A wrongly latched programming method causes the wrong register bits to change, and the readback after the first programming access reveals it. A reset that disturbs the thresholds is caught by the readback that follows each reset.

// File: rtl/pfl_pkg.sv
package pfl_pkg;

    typedef enum logic {
        LOAD_PARALLEL = 1'b0,
        LOAD_SERIAL   = 1'b1
    } load_mode_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_e;

    typedef struct packed {
        logic ser_shift;
        logic par_write;
        logic par_read;
    } load_req_t;

    // Reset default, saturated to the register width.
    function automatic logic [31:0] default_offset(input int unsigned width, input logic hi);
        logic [31:0] v;
        logic [31:0] cap;
        v   = hi ? 32'h0000_03FF : 32'h0000_007F;
        cap = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
        return (v > cap) ? cap : v;
    endfunction

    function automatic slot_e next_slot(input slot_e s);
        return (s == SLOT_EMPTY) ? SLOT_FULL : SLOT_EMPTY;
    endfunction

endpackage

// File: rtl/pfl_load_ctrl.sv
module pfl_load_ctrl
    import pfl_pkg::*;
(
    input  logic       clk,
    input  logic       mrst,
    input  logic       ser_sel,
    input  logic       cfg_ld,
    input  logic       wr_en,
    input  logic       rd_en,
    output load_mode_e load_mode,
    output load_req_t  req
);
    always_ff @(posedge clk) begin
        if (mrst) begin
            load_mode <= ser_sel ? LOAD_SERIAL : LOAD_PARALLEL;
        end
    end

    always_comb begin
        req.ser_shift = cfg_ld && wr_en && (load_mode == LOAD_SERIAL);
        req.par_write = cfg_ld && wr_en && (load_mode == LOAD_PARALLEL);
        req.par_read  = cfg_ld && rd_en;
    end
endmodule

// File: rtl/pfl_offset_regs.sv
module pfl_offset_regs
    import pfl_pkg::*;
#(
    parameter int unsigned W = 15
) (
    input  logic         clk,
    input  logic         mrst,
    input  logic         prst,
    input  logic         ld_level,
    input  load_req_t    req,
    input  logic         ser_bit,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] empty_off,
    output logic [W-1:0] full_off
);
    localparam int unsigned STREAM = 2 * W;
    localparam int unsigned IDX_W  = $clog2(STREAM);
    localparam logic [W-1:0] DFLT_LO = W'(default_offset(W, 1'b0));
    localparam logic [W-1:0] DFLT_HI = W'(default_offset(W, 1'b1));
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STREAM - 1);

    // Bits [W-1:0] hold the empty-side threshold, [2W-1:W] the full side.
    logic [STREAM-1:0] pair_q;
    logic [IDX_W-1:0]  ser_idx;
    slot_e             wr_slot;

    always_ff @(posedge clk) begin
        if (mrst) begin
            pair_q  <= ld_level ? {DFLT_HI, DFLT_HI} : {DFLT_LO, DFLT_LO};
            ser_idx <= '0;
            wr_slot <= SLOT_EMPTY;
        end else if (prst) begin
            ser_idx <= '0;
            wr_slot <= SLOT_EMPTY;
        end else begin
            if (req.ser_shift) begin
                pair_q[ser_idx] <= ser_bit;
                ser_idx <= (ser_idx == LAST_IDX) ? '0 : ser_idx + 1'b1;
            end
            if (req.par_write) begin
                if (wr_slot == SLOT_EMPTY) pair_q[W-1:0]      <= wr_data;
                else                       pair_q[STREAM-1:W] <= wr_data;
                wr_slot <= next_slot(wr_slot);
            end
        end
    end

    assign empty_off = pair_q[W-1:0];
    assign full_off  = pair_q[STREAM-1:W];
endmodule

// File: rtl/pfl_readback.sv
module pfl_readback
    import pfl_pkg::*;
#(
    parameter int unsigned W = 15
) (
    input  logic         clk,
    input  logic         mrst,
    input  logic         prst,
    input  logic         rd_req,
    input  logic [W-1:0] empty_off,
    input  logic [W-1:0] full_off,
    output logic [W-1:0] rd_data
);
    slot_e rd_slot;

    always_ff @(posedge clk) begin
        if (mrst) begin
            rd_slot <= SLOT_EMPTY;
            rd_data <= '0;
        end else if (prst) begin
            rd_slot <= SLOT_EMPTY;
        end else if (rd_req) begin
            rd_data <= (rd_slot == SLOT_EMPTY) ? empty_off : full_off;
            rd_slot <= next_slot(rd_slot);
        end
    end
endmodule

// File: rtl/pfl_flag_cmp.sv
module pfl_flag_cmp #(
    parameter int unsigned W = 15
) (
    input  logic [W:0]   fill_count,
    input  logic [W-1:0] empty_off,
    input  logic [W-1:0] full_off,
    output logic         almost_empty,
    output logic         almost_full
);
    localparam logic [W:0] DEPTH = {1'b1, {W{1'b0}}};

    logic [W:0] free_words;

    always_comb begin
        free_words   = DEPTH - fill_count;
        almost_empty = fill_count <= {1'b0, empty_off};
        almost_full  = free_words <= {1'b0, full_off};
    end
endmodule

// File: rtl/pfl_offset_loader.sv
module pfl_offset_loader
    import pfl_pkg::*;
#(
    parameter int unsigned W = 15
) (
    input  logic         clk,
    input  logic         mrst,
    input  logic         prst,
    input  logic         cfg_ld,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic         ser_sel,
    input  logic         ser_bit,
    input  logic [W-1:0] wr_data,
    input  logic [W:0]   fill_count,
    output logic [W-1:0] rd_data,
    output logic         almost_empty,
    output logic         almost_full
);
    load_mode_e   load_mode;
    load_req_t    req;
    logic [W-1:0] empty_off;
    logic [W-1:0] full_off;

    pfl_load_ctrl u_ctrl (
        .clk       (clk),
        .mrst      (mrst),
        .ser_sel   (ser_sel),
        .cfg_ld    (cfg_ld),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .load_mode (load_mode),
        .req       (req)
    );

    pfl_offset_regs #(.W(W)) u_regs (
        .clk       (clk),
        .mrst      (mrst),
        .prst      (prst),
        .ld_level  (cfg_ld),
        .req       (req),
        .ser_bit   (ser_bit),
        .wr_data   (wr_data),
        .empty_off (empty_off),
        .full_off  (full_off)
    );

    pfl_readback #(.W(W)) u_rdbk (
        .clk       (clk),
        .mrst      (mrst),
        .prst      (prst),
        .rd_req    (req.par_read),
        .empty_off (empty_off),
        .full_off  (full_off),
        .rd_data   (rd_data)
    );

    pfl_flag_cmp #(.W(W)) u_cmp (
        .fill_count   (fill_count),
        .empty_off    (empty_off),
        .full_off     (full_off),
        .almost_empty (almost_empty),
        .almost_full  (almost_full)
    );
endmodule

// File: rtl/pfl_offset_loader_checker.sv
module pfl_offset_loader_checker #(
    parameter int unsigned W = 15
) (
    input logic         clk,
    input logic         mrst,
    input logic         prst,
    input logic         cfg_ld,
    input logic         rd_en,
    input logic [W:0]   fill_count,
    input logic [W-1:0] rd_data,
    input logic         almost_empty,
    input logic         almost_full,
    input logic [W-1:0] empty_off,
    input logic [W-1:0] full_off,
    input logic         load_mode
);
    localparam logic [W:0] DEPTH = {1'b1, {W{1'b0}}};

    // R1: values present right after master reset match the selected default
    assert_mrst_default_R1: assert property (@(posedge clk) disable iff (mrst)
        $fell(mrst) |-> (empty_off == W'(pfl_pkg::default_offset(W, $past(cfg_ld))))
                     && (full_off  == W'(pfl_pkg::default_offset(W, $past(cfg_ld)))));

    // R2: partial reset keeps the thresholds
    assert_prst_keeps_R2: assert property (@(posedge clk) disable iff (mrst)
        prst |=> $stable(empty_off) && $stable(full_off));

    // R5: programming method only changes under master reset
    assert_mode_hold_R5: assert property (@(posedge clk) disable iff (mrst)
        !mrst |=> $stable(load_mode));

    // R7: readback bus holds without a read access
    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (mrst)
        !(cfg_ld && rd_en) |=> $stable(rd_data));

    // R8: an empty FIFO is always almost empty
    assert_empty_at_zero_R8: assert property (@(posedge clk) disable iff (mrst)
        (fill_count == '0) |-> almost_empty);

    // R9: a full FIFO is always almost full
    assert_full_at_depth_R9: assert property (@(posedge clk) disable iff (mrst)
        (fill_count == DEPTH) |-> almost_full);

    // R10: no threshold change without the access strobe
    assert_idle_no_change_R10: assert property (@(posedge clk) disable iff (mrst)
        !cfg_ld |=> $stable(empty_off) && $stable(full_off));
endmodule

bind pfl_offset_loader pfl_offset_loader_checker #(.W(W)) u_checker (
    .clk          (clk),
    .mrst         (mrst),
    .prst         (prst),
    .cfg_ld       (cfg_ld),
    .rd_en        (rd_en),
    .fill_count   (fill_count),
    .rd_data      (rd_data),
    .almost_empty (almost_empty),
    .almost_full  (almost_full),
    .empty_off    (empty_off),
    .full_off     (full_off),
    .load_mode    (load_mode)
);

// File: tb/pfl_offset_loader_bench.sv
module pfl_offset_loader_bench;
    localparam int W     = 15;
    localparam int DEPTH = 1 << W;

    logic         clk = 1'b0;
    logic         mrst = 1'b1;
    logic         prst = 1'b0;
    logic         cfg_ld = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic         ser_sel = 1'b0;
    logic         ser_bit = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W:0]   fill_count = '0;
    logic [W-1:0] rd_data;
    logic         almost_empty;
    logic         almost_full;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    // Bench model of the thresholds and sequencing state
    logic [2*W-1:0] pair_exp;
    int             ser_pos;
    int             wslot;
    bit             mode_ser;

    always #4 clk = ~clk;

    pfl_offset_loader #(.W(W)) u_pfl_offset_loader (
        .clk(clk), .mrst(mrst), .prst(prst), .cfg_ld(cfg_ld), .wr_en(wr_en),
        .rd_en(rd_en), .ser_sel(ser_sel), .ser_bit(ser_bit), .wr_data(wr_data),
        .fill_count(fill_count), .rd_data(rd_data),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_mrst(input logic ld_lvl, input logic ser_lvl);
        @(negedge clk);
        mrst = 1'b1; cfg_ld = ld_lvl; ser_sel = ser_lvl;
        @(negedge clk);
        mrst = 1'b0; cfg_ld = 1'b0; ser_sel = 1'b0;
        pair_exp = ld_lvl ? {15'h03FF, 15'h03FF} : {15'h007F, 15'h007F};
        ser_pos  = 0;
        wslot    = 0;
        mode_ser = ser_lvl;
    endtask

    task automatic do_prst();
        @(negedge clk);
        prst = 1'b1;
        @(negedge clk);
        prst = 1'b0;
        ser_pos = 0;
        wslot   = 0;
    endtask

    // R7: two reads return empty-side then full-side
    task automatic read_check(input string tag);
        @(negedge clk);
        cfg_ld = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        chk(rd_data == pair_exp[W-1:0], {tag, " R7 empty readback"}, rd_data, pair_exp[W-1:0]);
        @(negedge clk);
        cfg_ld = 1'b0; rd_en = 1'b0;
        chk(rd_data == pair_exp[2*W-1:W], {tag, " R7 full readback"}, rd_data, pair_exp[2*W-1:W]);
    endtask

    task automatic flag_at(input int f, input string tag);
        int e_t;
        int f_t;
        e_t = pair_exp[W-1:0];
        f_t = pair_exp[2*W-1:W];
        if (f < 0) f = 0;
        if (f > DEPTH) f = DEPTH;
        @(negedge clk);
        fill_count = (W+1)'(f);
        #1;
        chk(almost_empty == (f <= e_t), {tag, " R8 almost_empty"}, almost_empty, (f <= e_t));
        chk(almost_full == ((DEPTH - f) <= f_t), {tag, " R9 almost_full"}, almost_full, ((DEPTH - f) <= f_t));
    endtask

    task automatic flag_sweep(input string tag);
        int e_t;
        int f_t;
        e_t = pair_exp[W-1:0];
        f_t = pair_exp[2*W-1:W];
        flag_at(0, tag);          flag_at(1, tag);
        flag_at(e_t - 1, tag);    flag_at(e_t, tag);    flag_at(e_t + 1, tag);
        flag_at(DEPTH - f_t - 1, tag); flag_at(DEPTH - f_t, tag); flag_at(DEPTH - f_t + 1, tag);
        flag_at(DEPTH - 1, tag);  flag_at(DEPTH, tag);
    endtask

    task automatic par_write(input logic [W-1:0] v);
        @(negedge clk);
        cfg_ld = 1'b1; wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        cfg_ld = 1'b0; wr_en = 1'b0;
        if (wslot == 0) pair_exp[W-1:0] = v;
        else            pair_exp[2*W-1:W] = v;
        wslot = 1 - wslot;
    endtask

    task automatic ser_shift(input int nbits, input logic [2*W-1:0] stream, input logic sel_noise);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            cfg_ld = 1'b1; wr_en = 1'b1; ser_bit = stream[i]; ser_sel = sel_noise;
            pair_exp[ser_pos] = stream[i];
            ser_pos = (ser_pos == 2*W - 1) ? 0 : ser_pos + 1;
        end
        @(negedge clk);
        cfg_ld = 1'b0; wr_en = 1'b0; ser_sel = 1'b0;
    endtask

    task automatic t_defaults();
        @(negedge clk);
        chk(rd_data == '0, "R7 rd_data after reset", rd_data, 0);
        do_mrst(1'b0, 1'b0);
        read_check("R1 default low");
        flag_sweep("R1 default low");
        do_mrst(1'b1, 1'b0);
        read_check("R1 default high");
        flag_sweep("R1 default high");
    endtask

    task automatic t_parallel();
        do_mrst(1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            par_write(W'($urandom_range(1, DEPTH - 2)));
            par_write(W'($urandom_range(1, DEPTH - 2)));
            read_check("R6 parallel pair");
            flag_sweep("R6 parallel pair");
        end
        par_write(W'(16'h1234));
        read_check("R6 wrap to empty slot");
        // R5: ser_sel high later does not switch to serial
        @(negedge clk);
        ser_sel = 1'b1;
        par_write(W'(16'h0ABC));
        ser_sel = 1'b0;
        read_check("R5 parallel kept");
    endtask

    task automatic t_serial();
        logic [2*W-1:0] s;
        do_mrst(1'b1, 1'b1);
        for (int k = 0; k < 3; k++) begin
            s = {$urandom, $urandom};
            ser_shift(2*W, s, 1'b0);
            read_check("R3 serial stream");
            flag_sweep("R3 serial stream");
        end
        s = '0;
        ser_shift(5, s, 1'b0);
        read_check("R4 partial serial");
        s = '1;
        ser_shift(2*W + 3, s, 1'b0);
        read_check("R4 serial wrap");
        s = {$urandom, $urandom};
        ser_shift(7, s, 1'b1);
        read_check("R5 serial kept with ser_sel noise");
    endtask

    task automatic t_partial_reset();
        logic [2*W-1:0] s;
        do_mrst(1'b0, 1'b1);
        s = {$urandom, $urandom};
        ser_shift(2*W, s, 1'b0);
        s = '1;
        ser_shift(3, s, 1'b0);
        do_prst();
        read_check("R2 values kept");
        s = '0;
        ser_shift(2, s, 1'b0);
        read_check("R2 serial position restarted");
        do_mrst(1'b0, 1'b0);
        par_write(W'(16'h0111));
        do_prst();
        par_write(W'(16'h0222));
        read_check("R2 word slot restarted");
        // R2: read slot restarted after one read
        @(negedge clk);
        cfg_ld = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        cfg_ld = 1'b0; rd_en = 1'b0;
        do_prst();
        read_check("R2 read slot restarted");
    endtask

    task automatic t_ignore();
        logic [W-1:0] held;
        do_mrst(1'b0, 1'b0);
        par_write(W'(16'h0345));
        par_write(W'(16'h0456));
        read_check("R10 setup");
        held = rd_data;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            wr_en = 1'b1; rd_en = 1'b1; ser_bit = i[0]; wr_data = W'($urandom);
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk(rd_data == held, "R10 rd_data unchanged", rd_data, held);
        flag_sweep("R10 no load");
        read_check("R10 thresholds unchanged");
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_defaults();
        t_parallel();
        t_serial();
        t_partial_reset();
        t_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule